// File: doc/BRIEF.md
# AXI Transaction ID Remapper

This block sits on one address channel (write-address or read-address) between a group of bus masters that issue 12-bit transaction IDs and a cache-coherent slave port that understands only eight 3-bit IDs. Every accepted request is steered to one of eight slots. The slot number becomes the outgoing ID. The slot's 2-bit page field replaces the two most significant address bits, which selects one of four 1 GB regions. The slot's 5-bit user field is driven on the user sideband. On the response path, the 3-bit ID that comes back is turned into the original 12-bit ID through the slot table.

Each slot is configured by a 32-bit word written through a simple write port. A pinned slot serves exactly one master ID. An unpinned slot is lent to whichever ID needs it, and it returns to the free pool once all of its outstanding transactions have completed. Each slot keeps an outstanding counter. While that counter is nonzero, the slot's ID binding cannot change. A configuration word written to a busy slot is parked and takes effect when the slot drains.

The address path is a three-state machine. `ST_IDLE` means no request is pending. `ST_STALL` means a request is waiting with no usable slot. `ST_ISSUE` means a translated request is being presented downstream. The transitions are:
- idle-to-issue: a request is accepted.
- idle-to-stall: a request arrives and no slot can take it.
- stall-to-issue: a slot becomes usable.
- stall-to-idle: the request is withdrawn.
- issue-to-idle: the downstream port accepts and no new request is waiting.
- issue-to-issue: the downstream port accepts and the next request is granted in the same cycle.
- issue-to-stall: the downstream port accepts and the next request is waiting with no usable slot.

Top module: `axi_id_remap`

## Requirements
- R1: After reset, every slot is pinned to master ID 0x004, with page 0 and user 0x01. A request with ID 0x004 therefore leaves on virtual ID 0, and any other ID waits.
- R2: A configuration write to slot `cfg_slot` decodes the following fields from `cfg_wdata`:
  - bit 31 is the pin flag;
  - bits 27:16 are the master ID;
  - bits 13:12 are the page;
  - bits 8:4 are the user value.
  All other bits have no effect.
- R3: A pinned slot whose ID equals the request ID is chosen before any unpinned slot. When several pinned slots match, the lowest-numbered one is chosen.
- R4: The outgoing address equals the request address with its top two bits replaced by the chosen slot's page.
- R5: `m_user` carries the chosen slot's user field.
- R6: An unpinned slot that has outstanding transactions and holds the request ID is reused for that request.
- R7: When no slot matches, the lowest-numbered unpinned slot with zero outstanding transactions is taken, and it records the request ID.
- R8: When no slot can take a request, `s_ready` stays low until one frees.
- R9: A slot's counter rises on each accepted request. It falls only on a response handshake with `m_rsp_last` high.
- R10: `s_rsp_id` is the 12-bit ID held by the slot named by `m_rsp_id`. Valid, ready and last pass straight through between the two response sides.
- R11: A configuration write to a slot with outstanding transactions takes effect only after that slot's count returns to zero.
- R12: A request accepted on a clock edge is presented on `m_valid` from the next cycle. It is held with stable ID, address and user until `m_ready`.
- R13: A slot whose counter is at its maximum (15) accepts no further request until a response lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Slot written |
| cfg_wdata | input | 32 | Configuration word |
| s_valid | input | 1 | Request valid from master side |
| s_ready | output | 1 | Request accepted |
| s_id | input | 12 | Master transaction ID |
| s_addr | input | 32 | Request address |
| m_valid | output | 1 | Translated request valid |
| m_ready | input | 1 | Downstream ready |
| m_id | output | 3 | Virtual ID |
| m_addr | output | 32 | Rewritten address |
| m_user | output | 5 | User sideband |
| m_rsp_valid | input | 1 | Response valid from downstream |
| m_rsp_ready | output | 1 | Response ready toward downstream |
| m_rsp_id | input | 3 | Response virtual ID |
| m_rsp_last | input | 1 | Final beat of the response |
| s_rsp_valid | output | 1 | Response valid toward master |
| s_rsp_ready | input | 1 | Master ready for response |
| s_rsp_id | output | 12 | Restored master ID |
| s_rsp_last | output | 1 | Final beat toward master |

## Verification
The embedded properties check four things on every cycle:
- an accepted request appears downstream one cycle later and stays frozen while it is stalled;
- the presented page and user always agree with the slot named by `m_id`;
- no counter wraps in either direction;
- a busy slot never changes its ID binding.

Some behaviours depend on sequences of configuration and traffic, and only the directed scenarios can show them:
- which slot a request lands on (pinned priority, reuse, lowest free);
- that non-final beats keep a slot busy;
- that a parked configuration word waits for the drain;
- that reserved bits are ignored.

// File: rtl/axi_id_remap_pkg.sv
package axi_id_remap_pkg;

    localparam int MID_W     = 12;
    localparam int VID_W     = 3;
    localparam int NSLOT     = 1 << VID_W;
    localparam int PAGE_W    = 2;
    localparam int USER_W    = 5;
    localparam int CFG_W     = 32;

    // configuration word layout, decoded by the slot register
    localparam int PIN_BIT   = 31;
    localparam int MID_LSB   = 16;
    localparam int PAGE_LSB  = 12;
    localparam int USER_LSB  = 4;

    localparam logic              RST_PIN  = 1'b1;
    localparam logic [MID_W-1:0]  RST_MID  = 12'h004;
    localparam logic [PAGE_W-1:0] RST_PAGE = '0;
    localparam logic [USER_W-1:0] RST_USER = 5'h01;

    typedef struct packed {
        logic              pin;
        logic [MID_W-1:0]  mid;
        logic [PAGE_W-1:0] page;
        logic [USER_W-1:0] user;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STALL,
        ST_ISSUE
    } addr_state_e;

    function automatic slot_cfg_t unpack_cfg(input logic [CFG_W-1:0] word);
        slot_cfg_t c;
        c.pin  = word[PIN_BIT];
        c.mid  = word[MID_LSB  +: MID_W];
        c.page = word[PAGE_LSB +: PAGE_W];
        c.user = word[USER_LSB +: USER_W];
        return c;
    endfunction

endpackage

// File: rtl/axi_id_remap_slot.sv
module axi_id_remap_slot
    import axi_id_remap_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             alloc_we,
    input  logic [MID_W-1:0] alloc_mid,
    input  logic             inc,
    input  logic             dec,
    output slot_cfg_t        cfg_o,
    output logic             busy_o,
    output logic             full_o,
    output logic             eligible_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    slot_cfg_t        cfg_q;
    slot_cfg_t        pend_q;
    logic             pend_v_q;
    logic [CNT_W-1:0] cnt_q;
    logic             drained;

    assign drained = (cnt_q == '0);

    // outstanding transaction counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && !dec) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // live and parked configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.pin  <= RST_PIN;
            cfg_q.mid  <= RST_MID;
            cfg_q.page <= RST_PAGE;
            cfg_q.user <= RST_USER;
            pend_q     <= '0;
            pend_v_q   <= 1'b0;
        end else begin
            if (cfg_we) begin
                if (drained && !inc) begin
                    cfg_q    <= unpack_cfg(cfg_wdata);
                    pend_v_q <= 1'b0;
                end else begin
                    pend_q   <= unpack_cfg(cfg_wdata);
                    pend_v_q <= 1'b1;
                end
            end else if (pend_v_q && drained) begin
                cfg_q    <= pend_q;
                pend_v_q <= 1'b0;
            end
            if (alloc_we) begin
                cfg_q.mid <= alloc_mid;
            end
        end
    end

    assign cfg_o      = cfg_q;
    assign busy_o     = !drained;
    assign full_o     = (cnt_q == CNT_MAX);
    assign eligible_o = !(pend_v_q && drained);

    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |-> !(inc && !dec));

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> !dec);

    assert_binding_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!drained && !dec) |=> $stable(cfg_q.mid));

endmodule

// File: rtl/axi_id_remap_lookup.sv
module axi_id_remap_lookup
    import axi_id_remap_pkg::*;
(
    input  logic [MID_W-1:0]            req_mid,
    input  logic [NSLOT-1:0]            pin,
    input  logic [NSLOT-1:0][MID_W-1:0] mid,
    input  logic [NSLOT-1:0]            busy,
    input  logic [NSLOT-1:0]            eligible,
    output logic                        found,
    output logic                        alloc,
    output logic [VID_W-1:0]            vid
);

    logic             pin_hit, dyn_hit, free_hit;
    logic [VID_W-1:0] pin_vid, dyn_vid, free_vid;

    // descending scan so the lowest index is the last to be written
    always_comb begin
        pin_hit  = 1'b0;
        dyn_hit  = 1'b0;
        free_hit = 1'b0;
        pin_vid  = '0;
        dyn_vid  = '0;
        free_vid = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (eligible[i] && pin[i] && (mid[i] == req_mid)) begin
                pin_hit = 1'b1;
                pin_vid = VID_W'(i);
            end
            if (eligible[i] && !pin[i] && busy[i] && (mid[i] == req_mid)) begin
                dyn_hit = 1'b1;
                dyn_vid = VID_W'(i);
            end
            if (eligible[i] && !pin[i] && !busy[i]) begin
                free_hit = 1'b1;
                free_vid = VID_W'(i);
            end
        end
    end

    always_comb begin
        found = 1'b1;
        alloc = 1'b0;
        vid   = '0;
        if (pin_hit) begin
            vid = pin_vid;
        end else if (dyn_hit) begin
            vid = dyn_vid;
        end else if (free_hit) begin
            vid   = free_vid;
            alloc = 1'b1;
        end else begin
            found = 1'b0;
        end
    end

endmodule

// File: rtl/axi_id_remap.sv
module axi_id_remap
    import axi_id_remap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [VID_W-1:0]  cfg_slot,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [MID_W-1:0]  s_id,
    input  logic [ADDR_W-1:0] s_addr,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [VID_W-1:0]  m_id,
    output logic [ADDR_W-1:0] m_addr,
    output logic [USER_W-1:0] m_user,
    input  logic              m_rsp_valid,
    output logic              m_rsp_ready,
    input  logic [VID_W-1:0]  m_rsp_id,
    input  logic              m_rsp_last,
    output logic              s_rsp_valid,
    input  logic              s_rsp_ready,
    output logic [MID_W-1:0]  s_rsp_id,
    output logic              s_rsp_last
);

    localparam int OFS_W = ADDR_W - PAGE_W;

    addr_state_e state_q, state_d;

    slot_cfg_t [NSLOT-1:0]            cfg_arr;
    logic [NSLOT-1:0]                 pin_arr;
    logic [NSLOT-1:0][MID_W-1:0]      mid_arr;
    logic [NSLOT-1:0]                 busy, full, elig;

    logic             lk_found, lk_alloc;
    logic [VID_W-1:0] lk_vid;
    logic             grant, accept, rsp_hs;

    logic [VID_W-1:0]  m_id_q;
    logic [ADDR_W-1:0] m_addr_q;
    logic [USER_W-1:0] m_user_q;

    logic unused_addr_top;
    assign unused_addr_top = ^s_addr[ADDR_W-1 -: PAGE_W];

    assign rsp_hs = m_rsp_valid && s_rsp_ready && m_rsp_last;
    assign accept = s_valid && s_ready;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        axi_id_remap_slot #(.CNT_W(CNT_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we && (cfg_slot == VID_W'(g))),
            .cfg_wdata  (cfg_wdata),
            .alloc_we   (accept && lk_alloc && (lk_vid == VID_W'(g))),
            .alloc_mid  (s_id),
            .inc        (accept && (lk_vid == VID_W'(g))),
            .dec        (rsp_hs && (m_rsp_id == VID_W'(g))),
            .cfg_o      (cfg_arr[g]),
            .busy_o     (busy[g]),
            .full_o     (full[g]),
            .eligible_o (elig[g])
        );
        assign pin_arr[g] = cfg_arr[g].pin;
        assign mid_arr[g] = cfg_arr[g].mid;
    end

    axi_id_remap_lookup u_lookup (
        .req_mid  (s_id),
        .pin      (pin_arr),
        .mid      (mid_arr),
        .busy     (busy),
        .eligible (elig),
        .found    (lk_found),
        .alloc    (lk_alloc),
        .vid      (lk_vid)
    );

    assign grant = lk_found && !full[lk_vid];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (s_valid) begin
                    state_d = grant ? ST_ISSUE : ST_STALL;
                end
            end
            ST_STALL: begin
                if (!s_valid) begin
                    state_d = ST_IDLE;
                end else if (grant) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (m_ready) begin
                    if (s_valid && grant) begin
                        state_d = ST_ISSUE;
                    end else if (s_valid) begin
                        state_d = ST_STALL;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_ready = 1'b0;
        m_valid = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_STALL: s_ready = s_valid && grant;
            ST_ISSUE: begin
                m_valid = 1'b1;
                s_ready = s_valid && grant && m_ready;
            end
            default: ;
        endcase
    end

    // translated request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_id_q   <= '0;
            m_addr_q <= '0;
            m_user_q <= '0;
        end else if (accept) begin
            m_id_q   <= lk_vid;
            m_addr_q <= {cfg_arr[lk_vid].page, s_addr[OFS_W-1:0]};
            m_user_q <= cfg_arr[lk_vid].user;
        end
    end

    assign m_id   = m_id_q;
    assign m_addr = m_addr_q;
    assign m_user = m_user_q;

    // response path: ID restored from the slot table
    assign s_rsp_valid = m_rsp_valid;
    assign m_rsp_ready = s_rsp_ready;
    assign s_rsp_last  = m_rsp_last;
    assign s_rsp_id    = mid_arr[m_rsp_id];

    assert_issue_next_R12: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> m_valid);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_id) && $stable(m_addr) && $stable(m_user)));

    assert_page_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_addr[ADDR_W-1 -: PAGE_W] == cfg_arr[m_id].page));

    assert_user_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_user == cfg_arr[m_id].user));

endmodule

// File: tb/axi_id_remap_bench.sv
module axi_id_remap_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_slot = '0;
    logic [31:0] cfg_wdata = '0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [11:0] s_id = '0;
    logic [31:0] s_addr = '0;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [2:0]  m_id;
    logic [31:0] m_addr;
    logic [4:0]  m_user;
    logic        m_rsp_valid = 1'b0;
    logic        m_rsp_ready;
    logic [2:0]  m_rsp_id = '0;
    logic        m_rsp_last = 1'b0;
    logic        s_rsp_valid;
    logic        s_rsp_ready = 1'b1;
    logic [11:0] s_rsp_id;
    logic        s_rsp_last;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    axi_id_remap u_axi_id_remap (
        .clk, .rst_n, .cfg_we, .cfg_slot, .cfg_wdata,
        .s_valid, .s_ready, .s_id, .s_addr,
        .m_valid, .m_ready, .m_id, .m_addr, .m_user,
        .m_rsp_valid, .m_rsp_ready, .m_rsp_id, .m_rsp_last,
        .s_rsp_valid, .s_rsp_ready, .s_rsp_id, .s_rsp_last
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] slot, input logic [31:0] word);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = slot; cfg_wdata = word;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_req(input logic [11:0] id, input logic [31:0] addr);
        @(negedge clk);
        s_valid = 1'b1; s_id = id; s_addr = addr;
    endtask

    task automatic finish_accept(input string req);
        int w = 0;
        #1;
        while (!s_ready && w < 60) begin
            @(negedge clk); #1; w++;
        end
        chk({req, " accepted"}, {31'd0, s_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic expect_stall(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            chk({req, " stall"}, {31'd0, s_ready}, 32'd0);
        end
    endtask

    task automatic check_out(input logic [2:0] evid, input logic [31:0] eaddr,
                             input logic [4:0] euser, input string req);
        #1;
        chk({req, " m_valid"}, {31'd0, m_valid}, 32'd1);
        chk({req, " m_id"}, {29'd0, m_id}, {29'd0, evid});
        chk({req, " m_addr"}, m_addr, eaddr);
        chk({req, " m_user"}, {27'd0, m_user}, {27'd0, euser});
    endtask

    task automatic take_out();
        m_ready = 1'b1;
        @(negedge clk);
        m_ready = 1'b0;
    endtask

    task automatic issue(input logic [11:0] id, input logic [31:0] addr, input logic [2:0] evid,
                         input logic [31:0] eaddr, input logic [4:0] euser, input string req);
        start_req(id, addr);
        finish_accept(req);
        check_out(evid, eaddr, euser, req);
        take_out();
    endtask

    task automatic respond(input logic [2:0] vid, input logic last,
                           input logic [11:0] exp_id, input string req);
        @(negedge clk);
        m_rsp_valid = 1'b1; m_rsp_id = vid; m_rsp_last = last;
        #1;
        chk({req, " rsp valid"}, {31'd0, s_rsp_valid}, 32'd1);
        chk({req, " rsp id"}, {20'd0, s_rsp_id}, {20'd0, exp_id});
        chk({req, " rsp last"}, {31'd0, s_rsp_last}, {31'd0, last});
        @(negedge clk);
        m_rsp_valid = 1'b0; m_rsp_last = 1'b0;
    endtask

    // R1: reset defaults
    task automatic test_reset();
        #1;
        chk("R1 m_valid after reset", {31'd0, m_valid}, 32'd0);
        chk("R1 s_ready idle", {31'd0, s_ready}, 32'd0);
        issue(12'h004, 32'hFFFF_FFF0, 3'd0, 32'h3FFF_FFF0, 5'h01, "R1 default slot");
        respond(3'd0, 1'b1, 12'h004, "R10 slot0 restore");
    endtask

    // R8 and R7: stall with every slot pinned, then free slot 7
    task automatic test_stall_then_free();
        start_req(12'h123, 32'h0000_1000);
        expect_stall(4, "R8 all pinned");
        cfg_write(3'd7, 32'h0000_20A0);
        finish_accept("R7 slot7 freed");
        check_out(3'd7, 32'h8000_1000, 5'h0A, "R7 alloc slot7");
        take_out();
    endtask

    // R2: field decode, reserved bits set in slots 5 and 1
    task automatic setup_slots();
        cfg_write(3'd4, 32'h0000_1110);
        cfg_write(3'd5, 32'h7000_FFFF);
        cfg_write(3'd6, 32'h0000_0020);
        cfg_write(3'd1, 32'hFABC_FF5F);
        cfg_write(3'd2, 32'h8123_1030);
    endtask

    // R3 R4 R5 R2
    task automatic test_pinned();
        issue(12'hABC, 32'h1234_5678, 3'd1, 32'hD234_5678, 5'h15, "R2 R3 pinned reserved bits");
        respond(3'd1, 1'b1, 12'hABC, "R10 slot1");
        issue(12'h123, 32'h4000_0004, 3'd2, 32'h4000_0004, 5'h03, "R3 pinned over active dynamic");
        respond(3'd2, 1'b1, 12'h123, "R10 slot2");
        respond(3'd7, 1'b1, 12'h123, "R10 dynamic slot7");
    endtask

    // R6 R7 R4 R5
    task automatic test_dynamic();
        issue(12'h555, 32'hC000_0000, 3'd4, 32'h4000_0000, 5'h11, "R7 first free slot4");
        issue(12'h555, 32'h0000_0010, 3'd4, 32'h4000_0010, 5'h11, "R6 reuse slot4");
        issue(12'h666, 32'h0000_0000, 3'd5, 32'hC000_0000, 5'h1F, "R7 next free slot5 R2");
        issue(12'h777, 32'h0000_0020, 3'd6, 32'h0000_0020, 5'h02, "R7 slot6");
        issue(12'h999, 32'h0000_0001, 3'd7, 32'h8000_0001, 5'h0A, "R7 slot7 reallocated");
    endtask

    // R8 R9 R10
    task automatic test_response_free();
        start_req(12'h888, 32'h0000_0010);
        expect_stall(3, "R8 dynamic exhausted");
        respond(3'd5, 1'b0, 12'h666, "R10 beat not last");
        expect_stall(2, "R9 non-last keeps busy");
        respond(3'd5, 1'b1, 12'h666, "R10 last beat");
        finish_accept("R9 slot5 freed");
        check_out(3'd5, 32'hC000_0010, 5'h1F, "R9 slot5 reused for new ID");
        take_out();
    endtask

    // R11
    task automatic test_deferred();
        cfg_write(3'd4, 32'h80F0_2070);
        issue(12'h555, 32'h0000_0100, 3'd4, 32'h4000_0100, 5'h11, "R11 old config while busy");
        respond(3'd4, 1'b1, 12'h555, "R11 drain 1");
        respond(3'd4, 1'b1, 12'h555, "R11 drain 2");
        respond(3'd4, 1'b1, 12'h555, "R11 drain 3");
        issue(12'h0F0, 32'h0000_0003, 3'd4, 32'h8000_0003, 5'h07, "R11 new config after drain");
    endtask

    // R12
    task automatic test_hold();
        start_req(12'h004, 32'h0000_0005);
        finish_accept("R12 accept");
        for (int k = 0; k < 3; k++) begin
            check_out(3'd0, 32'h0000_0005, 5'h01, "R12 held");
            @(negedge clk);
        end
        take_out();
        #1;
        chk("R12 m_valid drops", {31'd0, m_valid}, 32'd0);
        respond(3'd0, 1'b1, 12'h004, "R10 slot0 again");
    endtask

    // R13
    task automatic test_full();
        for (int k = 0; k < 15; k++) begin
            issue(12'hABC, 32'h0000_0100 + k, 3'd1, 32'hC000_0100 + k, 5'h15, "R13 fill");
        end
        start_req(12'hABC, 32'h0000_0200);
        expect_stall(3, "R13 counter full");
        respond(3'd1, 1'b1, 12'hABC, "R13 one response");
        finish_accept("R13 after response");
        check_out(3'd1, 32'hC000_0200, 5'h15, "R13 granted");
        take_out();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_stall_then_free();
        setup_slots();
        test_pinned();
        test_dynamic();
        test_response_free();
        test_deferred();
        test_hold();
        test_full();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R12: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule